// File: doc/BRIEF.md
# Multi-Channel Packet Memory Arbiter

This block sits between a CPU register bus and a USB serial interface engine and gives both of them access to one single-port packet SRAM. The SRAM is split into channels. Each channel has a write pointer, a read pointer and a data port, all reachable from the CPU. A CPU store through the data port writes at the write pointer and then advances it. A CPU load through the data port returns a byte that was fetched earlier, advances the read pointer and fetches the next byte in the background. Writing the read pointer starts that background fetch, so the first load already returns real data.

The engine does not use the pointers as cursors. It gives a channel number and a byte offset. The block adds the offset to the channel's write pointer for an engine store (an OUT transfer) or to its read pointer for an engine load (an IN transfer). Each engine store is compared with the endpoint byte count that comes with it. A store whose offset has reached that count is dropped.

The SRAM port serves the engine first. A CPU access is held in a one-entry slot and done in the next clock that the engine leaves free. This finishes well inside one CPU bus cycle, so the CPU never waits. The rules for this are: CPU strobes at least three clocks apart, engine strobes at least two clocks apart, and CPU code never uses a channel that the engine is using. All addresses are 9 bits wide and wrap modulo 512, and no address is range-checked.

Top module: `pktmem_arbiter`

## Requirements
- R1: After a synchronous active-low reset, every channel's write pointer, read pointer and fetched byte read as 0, and `eng_rdata` is 0.
- R2: The CPU register select picks one of four registers: 0 is the write pointer, 1 is the read pointer, 2 is the data port, and 3 is unused. Both pointers read back the value written to them. Select 3 reads as 0, and a write to it changes no register.
- R3: A CPU write to select 2 stores the low 8 bits of `cpu_wdata` at the channel's write pointer. The pointer reads one higher from the next clock onward.
- R4: A CPU write to select 1 loads the read pointer and fetches the byte at that address. A data-port read issued three clocks later returns that byte.
- R5: A CPU read of select 2 returns the fetched byte combinationally. It then increments the read pointer and fetches the byte at the new address, ready for the next read three clocks later.
- R6: An engine load (`eng_rd`) returns the byte at (read pointer + `eng_ofs`) mod 512 on `eng_rdata` one clock later.
- R7: An engine store (`eng_wr`) writes `eng_wdata` at (write pointer + `eng_ofs`) mod 512 only when `eng_ofs` < `eng_limit`. Otherwise the SRAM is left unchanged.
- R8: Pointers wrap from 511 to 0, and a pointer plus offset sum wraps modulo 512.
- R9: When engine and CPU requests meet, the engine gets the SRAM clock and the CPU access completes on the next clock. A stream of CPU data accesses three clocks apart returns and stores correct data while the engine runs back-to-back accesses on another channel.
- R10: Only CPU accesses change pointers. Engine loads and stores leave both pointers of every channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_ch | input | 2 | CPU channel index |
| cpu_sel | input | 2 | CPU register select (0 write ptr, 1 read ptr, 2 data, 3 unused) |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_rd | input | 1 | CPU register read strobe (acts on select 2 only) |
| cpu_wdata | input | 9 | CPU write value (pointer, or byte in bits 7:0) |
| cpu_rdata | output | 9 | Combinational read value of the selected register |
| eng_ch | input | 2 | Engine channel index |
| eng_ofs | input | 9 | Engine byte offset from the channel base |
| eng_rd | input | 1 | Engine load strobe |
| eng_wr | input | 1 | Engine store strobe |
| eng_wdata | input | 8 | Engine store byte |
| eng_limit | input | 9 | Endpoint byte count that caps engine stores |
| eng_rdata | output | 8 | Engine load byte, valid one clock after `eng_rd` |

## Verification
On every clock the assertions check four things: the engine and the CPU are never granted the SRAM in the same clock, a waiting CPU access is served as soon as the engine is idle, an engine store at or beyond its byte count never reaches the SRAM, and pointers move only on CPU accesses. The bench scenarios are needed for the data itself. They show that the background fetch returns the right byte after a read pointer write and after each load, that engine offsets land at the right addresses, that addresses wrap at 511, and that a CPU stream running alongside steady engine traffic stores and returns correct bytes.

// File: rtl/pkm_pkg.sv
// Package pkm_pkg: shared encodings for the packet memory arbiter.
// Assumes: register select is 2 bits; the pending CPU operation is a store or a fetch.
package pkm_pkg;
    typedef enum logic [1:0] {
        SEL_WPTR = 2'd0,
        SEL_RPTR = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        OP_STORE = 1'b0,
        OP_FETCH = 1'b1
    } mem_op_e;
endpackage

// File: rtl/pkm_sram.sv
// Module pkm_sram: single-port packet store with 2**ADDR_W bytes.
// Writes happen on the clock edge. The read value is presented combinationally,
// and the requester registers it, which acts as the SRAM output register.
// Assumes: one access per clock, chosen by the arbiter. The contents have no reset.
module pkm_sram #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store one byte when the granted requester writes.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Present the addressed byte to whichever requester holds the port.
    always_comb begin
        rdata = mem[addr];
    end
endmodule

// File: rtl/pkm_channel.sv
// Module pkm_channel: pointer pair and fetched byte for one channel.
// The write pointer moves on CPU data stores. The read pointer moves on CPU data loads.
// The fetched byte is refilled whenever the arbiter completes a fetch for this channel.
// Assumes: at most one CPU strobe per clock. Engine traffic never reaches these registers.
module pkm_channel
    import pkm_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  reg_sel_e          sel,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [ADDR_W-1:0] cpu_wdata,
    input  logic              fill_en,
    input  logic [DATA_W-1:0] fill_data,
    output logic [ADDR_W-1:0] wptr,
    output logic [ADDR_W-1:0] rptr,
    output logic [DATA_W-1:0] pbuf
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    // Pointer updates: a load writes the pointer, a data access advances it by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else if (hit && cpu_wr) begin
            case (sel)
                SEL_WPTR: wptr <= cpu_wdata;
                SEL_RPTR: rptr <= cpu_wdata;
                SEL_DATA: wptr <= wptr + STEP;
                default:  ;
            endcase
        end else if (hit && cpu_rd && sel == SEL_DATA) begin
            rptr <= rptr + STEP;
        end
    end

    // Fetched byte: capture the SRAM value when a fetch for this channel completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pbuf <= '0;
        end else if (fill_en) begin
            pbuf <= fill_data;
        end
    end

    // R10: pointers stay put in any clock without a CPU strobe on this channel.
    assert_ptr_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && (cpu_wr || cpu_rd)) |=> ($stable(wptr) && $stable(rptr)));
endmodule

// File: rtl/pkm_arbiter.sv
// Module pkm_arbiter: owns the single SRAM port.
// An engine request is served in the clock it arrives. A CPU request is parked in a
// one-entry slot and served in the first clock the engine leaves free.
// Assumes: CPU requests are at least 3 clocks apart and engine requests at least
// 2 clocks apart, so a parked request waits at most one extra clock.
module pkm_arbiter
    import pkm_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8,
    parameter int CH_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  mem_op_e           cpu_op,
    input  logic [CH_W-1:0]   cpu_ch,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              eng_req,
    input  logic              eng_we,
    input  logic [ADDR_W-1:0] eng_addr,
    input  logic [DATA_W-1:0] eng_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              fill_en,
    output logic [CH_W-1:0]   fill_ch
);
    logic              pend_valid;
    mem_op_e           pend_op;
    logic [CH_W-1:0]   pend_ch;
    logic [ADDR_W-1:0] pend_addr;
    logic [DATA_W-1:0] pend_data;
    logic              cpu_go;

    // Grant: the engine always wins, and the parked CPU request takes the idle clocks.
    always_comb begin
        cpu_go = pend_valid && !eng_req;
    end

    // Parking slot: accept a new CPU request, release it once granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_op    <= OP_STORE;
            pend_ch    <= '0;
            pend_addr  <= '0;
            pend_data  <= '0;
        end else if (cpu_req) begin
            pend_valid <= 1'b1;
            pend_op    <= cpu_op;
            pend_ch    <= cpu_ch;
            pend_addr  <= cpu_addr;
            pend_data  <= cpu_data;
        end else if (cpu_go) begin
            pend_valid <= 1'b0;
        end
    end

    // Port mux: drive the SRAM from the granted requester.
    always_comb begin
        if (eng_req) begin
            mem_addr  = eng_addr;
            mem_we    = eng_we;
            mem_wdata = eng_data;
        end else begin
            mem_addr  = pend_addr;
            mem_we    = cpu_go && (pend_op == OP_STORE);
            mem_wdata = pend_data;
        end
        fill_en = cpu_go && (pend_op == OP_FETCH);
        fill_ch = pend_ch;
    end

    // R9: the two requesters never share an SRAM clock.
    assert_single_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eng_req, cpu_go}));

    // R9: a parked CPU access is gone one clock after an engine-free clock.
    assert_pend_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && !eng_req && !cpu_req) |=> !pend_valid);

    // R9: usage rule, a new CPU request never finds the slot still occupied.
    assert_cpu_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> !pend_valid);

    // R9: usage rule, engine requests never come in consecutive clocks.
    assert_eng_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |=> !eng_req);
endmodule

// File: rtl/pktmem_arbiter.sv
// Module pktmem_arbiter: top level of the multi-channel packet memory arbiter.
// Decodes the CPU register bus into pointer updates and SRAM requests, forms
// engine addresses as channel base plus offset, caps engine stores at the
// endpoint byte count, and registers engine load data.
// Assumes: NUM_CH is a power of two, ADDR_W > DATA_W, and the strobe spacing
// described in pkm_arbiter.
module pktmem_arbiter
    import pkm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(NUM_CH)-1:0] cpu_ch,
    input  logic [1:0]                cpu_sel,
    input  logic                      cpu_wr,
    input  logic                      cpu_rd,
    input  logic [ADDR_W-1:0]         cpu_wdata,
    output logic [ADDR_W-1:0]         cpu_rdata,
    input  logic [$clog2(NUM_CH)-1:0] eng_ch,
    input  logic [ADDR_W-1:0]         eng_ofs,
    input  logic                      eng_rd,
    input  logic                      eng_wr,
    input  logic [DATA_W-1:0]         eng_wdata,
    input  logic [ADDR_W-1:0]         eng_limit,
    output logic [DATA_W-1:0]         eng_rdata
);
    localparam int CH_W  = $clog2(NUM_CH);
    localparam int PAD_W = ADDR_W - DATA_W;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    reg_sel_e          sel;
    logic [ADDR_W-1:0] wptr_a [NUM_CH];
    logic [ADDR_W-1:0] rptr_a [NUM_CH];
    logic [DATA_W-1:0] pbuf_a [NUM_CH];

    logic              cpu_req;
    mem_op_e           cpu_op;
    logic [ADDR_W-1:0] cpu_addr;
    logic              eng_req;
    logic              eng_we;
    logic [ADDR_W-1:0] eng_addr;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;
    logic              fill_en;
    logic [CH_W-1:0]   fill_ch;

    // Select decode: give the raw select bits their register meaning.
    always_comb begin
        sel = reg_sel_e'(cpu_sel);
    end

    // Channel register banks, one per channel.
    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
        pkm_channel #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit       (cpu_ch == CH_W'(gi)),
            .sel       (sel),
            .cpu_wr    (cpu_wr),
            .cpu_rd    (cpu_rd),
            .cpu_wdata (cpu_wdata),
            .fill_en   (fill_en && (fill_ch == CH_W'(gi))),
            .fill_data (mem_rdata),
            .wptr      (wptr_a[gi]),
            .rptr      (rptr_a[gi]),
            .pbuf      (pbuf_a[gi])
        );
    end

    // CPU request forming: a data store, a read-pointer preload, or a load's next fetch.
    always_comb begin
        cpu_req  = 1'b0;
        cpu_op   = OP_FETCH;
        cpu_addr = '0;
        if (cpu_wr && sel == SEL_DATA) begin
            cpu_req  = 1'b1;
            cpu_op   = OP_STORE;
            cpu_addr = wptr_a[cpu_ch];
        end else if (cpu_wr && sel == SEL_RPTR) begin
            cpu_req  = 1'b1;
            cpu_addr = cpu_wdata;
        end else if (cpu_rd && sel == SEL_DATA) begin
            cpu_req  = 1'b1;
            cpu_addr = rptr_a[cpu_ch] + STEP;
        end
    end

    // CPU read mux: pointers as they are, the fetched byte zero-extended, select 3 as zero.
    always_comb begin
        case (sel)
            SEL_WPTR: cpu_rdata = wptr_a[cpu_ch];
            SEL_RPTR: cpu_rdata = rptr_a[cpu_ch];
            SEL_DATA: cpu_rdata = {{PAD_W{1'b0}}, pbuf_a[cpu_ch]};
            default:  cpu_rdata = '0;
        endcase
    end

    // Engine address and cap: base pointer by direction plus offset, stores under the count only.
    always_comb begin
        eng_req  = eng_rd || eng_wr;
        eng_addr = (eng_wr ? wptr_a[eng_ch] : rptr_a[eng_ch]) + eng_ofs;
        eng_we   = eng_wr && (eng_ofs < eng_limit);
    end

    pkm_arbiter #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CH_W   (CH_W)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_op    (cpu_op),
        .cpu_ch    (cpu_ch),
        .cpu_addr  (cpu_addr),
        .cpu_data  (cpu_wdata[DATA_W-1:0]),
        .eng_req   (eng_req),
        .eng_we    (eng_we),
        .eng_addr  (eng_addr),
        .eng_data  (eng_wdata),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .fill_en   (fill_en),
        .fill_ch   (fill_ch)
    );

    pkm_sram #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_sram (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    // Engine load register: hold the byte read in the engine's clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_rdata <= '0;
        end else if (eng_rd) begin
            eng_rdata <= mem_rdata;
        end
    end

    // R7: a store at or past the endpoint count never writes the SRAM.
    assert_store_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_wr && (eng_ofs >= eng_limit)) |-> !mem_we);

    // R2: usage rule, never a read and a write strobe in the same clock.
    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && cpu_rd));
endmodule

// File: tb/pktmem_arbiter_bench.sv
// Bench for pktmem_arbiter: a vector table walked by one loop, then directed
// tests for reset, address wrap, concurrent streaming and a second reset.
module pktmem_arbiter_bench;
    localparam logic [1:0] K_CW = 2'd0;  // CPU register write
    localparam logic [1:0] K_CR = 2'd1;  // CPU register read, checked
    localparam logic [1:0] K_EW = 2'd2;  // engine store
    localparam logic [1:0] K_ER = 2'd3;  // engine load, checked

    typedef struct packed {
        logic [1:0] kind;
        logic [1:0] ch;
        logic [8:0] a;    // register select or engine offset
        logic [8:0] d;    // write value or expected value
        logic [8:0] lim;  // engine byte count
        logic [3:0] rq;   // requirement number
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{K_CW, 2'd0, 9'd0, 9'd10,   9'd0, 4'd2},   // R2 set write pointer
        '{K_CW, 2'd0, 9'd2, 9'h0A1,  9'd0, 4'd3},   // R3 store at 10
        '{K_CW, 2'd0, 9'd2, 9'h0A2,  9'd0, 4'd3},   // R3 store at 11
        '{K_CR, 2'd0, 9'd0, 9'd12,   9'd0, 4'd3},   // R3 pointer advanced twice
        '{K_CW, 2'd1, 9'd1, 9'd10,   9'd0, 4'd4},   // R4 preload from 10
        '{K_CR, 2'd1, 9'd1, 9'd10,   9'd0, 4'd2},   // R2 read pointer readback
        '{K_CR, 2'd1, 9'd2, 9'h0A1,  9'd0, 4'd4},   // R4 first load valid
        '{K_CR, 2'd1, 9'd2, 9'h0A2,  9'd0, 4'd5},   // R5 next fetched byte
        '{K_CR, 2'd1, 9'd1, 9'd12,   9'd0, 4'd5},   // R5 read pointer advanced
        '{K_CW, 2'd0, 9'd0, 9'd102,  9'd0, 4'd2},   // R2 move write pointer
        '{K_CW, 2'd0, 9'd2, 9'h033,  9'd0, 4'd3},   // R3 seed 102
        '{K_CW, 2'd2, 9'd0, 9'd100,  9'd0, 4'd7},   // R7 engine store base
        '{K_EW, 2'd2, 9'd0, 9'h055,  9'd2, 4'd7},   // R7 store at 100
        '{K_EW, 2'd2, 9'd1, 9'h066,  9'd2, 4'd7},   // R7 store at 101
        '{K_EW, 2'd2, 9'd2, 9'h077,  9'd2, 4'd7},   // R7 capped, 102 kept
        '{K_CW, 2'd3, 9'd1, 9'd100,  9'd0, 4'd6},   // R6 engine load base
        '{K_ER, 2'd3, 9'd1, 9'h066,  9'd0, 4'd6},   // R6 load 101
        '{K_ER, 2'd3, 9'd0, 9'h055,  9'd0, 4'd6},   // R6 load 100
        '{K_ER, 2'd3, 9'd2, 9'h033,  9'd0, 4'd7},   // R7 capped store left 102
        '{K_CR, 2'd2, 9'd0, 9'd100,  9'd0, 4'd10},  // R10 engine kept wptr
        '{K_CR, 2'd3, 9'd1, 9'd100,  9'd0, 4'd10},  // R10 engine kept rptr
        '{K_CW, 2'd0, 9'd3, 9'h1FF,  9'd0, 4'd2},   // R2 write to unused select
        '{K_CR, 2'd0, 9'd3, 9'd0,    9'd0, 4'd2},   // R2 unused select reads 0
        '{K_CR, 2'd0, 9'd0, 9'd103,  9'd0, 4'd2},   // R2 wptr untouched by select 3
        '{K_EW, 2'd2, 9'd3, 9'h088,  9'd4, 4'd7},   // R7 below count, store at 103
        '{K_ER, 2'd3, 9'd3, 9'h088,  9'd0, 4'd7}    // R7 stored byte visible
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cpu_ch = '0;
    logic [1:0] cpu_sel = '0;
    logic       cpu_wr = 1'b0;
    logic       cpu_rd = 1'b0;
    logic [8:0] cpu_wdata = '0;
    logic [8:0] cpu_rdata;
    logic [1:0] eng_ch = '0;
    logic [8:0] eng_ofs = '0;
    logic       eng_rd = 1'b0;
    logic       eng_wr = 1'b0;
    logic [7:0] eng_wdata = '0;
    logic [8:0] eng_limit = 9'h1FF;
    logic [7:0] eng_rdata;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pktmem_arbiter u_pktmem_arbiter (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_ch    (cpu_ch),
        .cpu_sel   (cpu_sel),
        .cpu_wr    (cpu_wr),
        .cpu_rd    (cpu_rd),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .eng_ch    (eng_ch),
        .eng_ofs   (eng_ofs),
        .eng_rd    (eng_rd),
        .eng_wr    (eng_wr),
        .eng_wdata (eng_wdata),
        .eng_limit (eng_limit),
        .eng_rdata (eng_rdata)
    );

    task automatic check(input int rq, input logic [8:0] act, input logic [8:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // CPU write: strobe one clock, then two idle clocks.
    task automatic cpu_write(input logic [1:0] ch, input logic [1:0] s, input logic [8:0] v);
        @(negedge clk);
        cpu_ch = ch; cpu_sel = s; cpu_wdata = v; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
        @(negedge clk);
    endtask

    // CPU read: value checked while the strobe is up, then two idle clocks.
    task automatic cpu_read(input logic [1:0] ch, input logic [1:0] s, input logic [8:0] exp,
                            input int rq, input string what);
        @(negedge clk);
        cpu_ch = ch; cpu_sel = s; cpu_rd = (s == 2'd2);
        #1;
        check(rq, cpu_rdata, exp, what);
        @(negedge clk);
        cpu_rd = 1'b0;
        @(negedge clk);
    endtask

    // Engine store: strobe one clock, one idle clock.
    task automatic eng_store(input logic [1:0] ch, input logic [8:0] ofs, input logic [7:0] v,
                             input logic [8:0] lim);
        @(negedge clk);
        eng_ch = ch; eng_ofs = ofs; eng_wdata = v; eng_limit = lim; eng_wr = 1'b1;
        @(negedge clk);
        eng_wr = 1'b0;
    endtask

    // Engine load: strobe one clock, result checked one clock later.
    task automatic eng_load(input logic [1:0] ch, input logic [8:0] ofs, input logic [7:0] exp,
                            input int rq, input string what);
        @(negedge clk);
        eng_ch = ch; eng_ofs = ofs; eng_rd = 1'b1;
        @(negedge clk);
        eng_rd = 1'b0;
        check(rq, {1'b0, eng_rdata}, {1'b0, exp}, what);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every channel and the engine output.
        for (int c = 0; c < 4; c++) begin
            cpu_read(2'(c), 2'd0, 9'd0, 1, "reset wptr");
            cpu_read(2'(c), 2'd1, 9'd0, 1, "reset rptr");
        end
        check(1, {1'b0, eng_rdata}, 9'd0, "reset eng_rdata");
        cpu_ch = 2'd0; cpu_sel = 2'd2; #1;
        check(1, cpu_rdata, 9'd0, "reset fetched byte");

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            case (VECS[i].kind)
                K_CW: cpu_write(VECS[i].ch, VECS[i].a[1:0], VECS[i].d);
                K_CR: cpu_read(VECS[i].ch, VECS[i].a[1:0], VECS[i].d, int'(VECS[i].rq), "vector read");
                K_EW: eng_store(VECS[i].ch, VECS[i].a, VECS[i].d[7:0], VECS[i].lim);
                default: eng_load(VECS[i].ch, VECS[i].a, VECS[i].d[7:0], int'(VECS[i].rq), "vector load");
            endcase
        end

        // R8: pointer and offset wrap at 511.
        cpu_write(2'd0, 2'd0, 9'd511);
        cpu_write(2'd0, 2'd2, 9'h0C3);
        cpu_write(2'd0, 2'd2, 9'h0C4);
        cpu_read(2'd0, 2'd0, 9'd1, 8, "wptr wrapped");
        cpu_write(2'd1, 2'd1, 9'd511);
        cpu_read(2'd1, 2'd2, 9'h0C3, 8, "load at 511");
        cpu_read(2'd1, 2'd2, 9'h0C4, 8, "load after wrap");
        cpu_read(2'd1, 2'd1, 9'd1, 8, "rptr wrapped");
        cpu_write(2'd2, 2'd1, 9'd510);
        eng_load(2'd2, 9'd2, 8'hC4, 8, "engine sum wraps");

        // R9: CPU stream on channels 0/1 while the engine loads back-to-back on channel 3.
        fork
            begin
                cpu_write(2'd0, 2'd0, 9'd200);
                for (int k = 0; k < 8; k++) cpu_write(2'd0, 2'd2, 9'(8'h10 + k));
                cpu_write(2'd1, 2'd1, 9'd200);
                for (int k = 0; k < 8; k++) cpu_read(2'd1, 2'd2, 9'(8'h10 + k), 9, "stream load");
                cpu_read(2'd0, 2'd0, 9'd208, 9, "stream wptr");
            end
            begin
                for (int k = 0; k < 27; k++) eng_load(2'd3, 9'd0, 8'h55, 9, "engine during stream");
            end
        join

        // R1: a second reset clears state after activity.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cpu_read(2'd0, 2'd0, 9'd0, 1, "wptr after reset");
        cpu_read(2'd3, 2'd1, 9'd0, 1, "rptr after reset");
        check(1, {1'b0, eng_rdata}, 9'd0, "eng_rdata after reset");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule